// File: doc/BRIEF.md
# Redundant-Binary to Two's-Complement Converter

This block takes a signed-digit result held as two unsigned rows, a positive row and a negative row, and turns it into an ordinary two's-complement word by computing positive minus negative modulo 2^W. It is the last stage behind a carry-free partial-product summing tree. That stage is the only place in the datapath where a carry has to travel across the full word, from the least significant bit to the most significant.

The subtraction is done as positive + ~negative + 1, with the +1 entering as a fixed carry into bit 0. The default variant uses a parallel-prefix network in Ling form. The pseudo-carry H_k = g_k | c_(k-1) is computed by two interleaved prefix trees, one over the even positions and one over the odd positions, each working at stride two. The true carry is then recovered as t_k & H_k. A parameter switches to a ripple chain of full adders instead, so the two variants can be compared for area and delay. In the ripple chain the lowest stage is reduced to a half-adder-sized cell, because its carry-in is always 1. The block is purely combinational.

Top module: `rb_to_binary`

## Requirements
- R1: `result` equals (`pos_row` - `neg_row`) mod 2^W for every pair of input rows.
- R2: When both rows are all zero, `result` is all zero.
- R3: When `neg_row` is zero, `result` equals `pos_row`.
- R4: When the two rows are equal, `result` is zero.
- R5: The ripple variant (`USE_RIPPLE` = 1) produces the same `result` as the prefix variant (`USE_RIPPLE` = 0) on every input.
- R6: When `pos_row` is zero, `result` is the two's-complement negation of `neg_row`. For example, an all-ones `neg_row` gives the value 1, and a `neg_row` with only bit W-1 set gives that same word back.
- R7: An all-ones `pos_row` minus a zero `neg_row` gives all ones, and a zero `pos_row` minus an all-ones `neg_row` gives 1, so that a borrow travels across the whole word.
- R8: With alternating bit patterns and W = 32, 0xAAAAAAAA - 0x55555555 gives 0x55555555, and 0x55555555 - 0xAAAAAAAA gives 0xAAAAAAAB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pos_row | input | W | Positive row of the redundant-binary value |
| neg_row | input | W | Negative row of the redundant-binary value |
| result | output | W | Two's-complement value pos_row - neg_row |

## Verification
Every result is combinational, so it is due in the same cycle as its stimulus, with no register on the path. The driver applies each operand pair on a falling clock edge and queues the expected word. The monitor pops that entry and compares both variants on the following rising edge, half a period later, when the inputs are stable and the logic has settled. Directed pairs (zeros, ones, alternating bits, equal rows, the sign bit alone) are followed by random pairs. The two variants are also compared against each other.

// File: rtl/rb_to_binary.sv
module rb_to_binary #(
  parameter int W          = 32,
  parameter bit USE_RIPPLE = 1'b0
) (
  input  logic [W-1:0] pos_row,
  input  logic [W-1:0] neg_row,
  output logic [W-1:0] result
);

  logic [W-1:0] opa, opb;
  assign opa = pos_row;
  assign opb = ~neg_row;

  if (USE_RIPPLE) begin : g_ripple
    logic [W-2:0] cy;
    for (genvar j = 0; j < W; j++) begin : g_bit
      if (j == 0) begin : g_lsb
        assign result[0] = ~(opa[0] ^ opb[0]);
        assign cy[0]     = opa[0] | opb[0];
      end else if (j < W-1) begin : g_mid
        assign result[j] = opa[j] ^ opb[j] ^ cy[j-1];
        assign cy[j]     = (opa[j] & opb[j]) | ((opa[j] ^ opb[j]) & cy[j-1]);
      end else begin : g_msb
        assign result[j] = opa[j] ^ opb[j] ^ cy[j-1];
      end
    end
  end else begin : g_ling
    localparam int LV = $clog2((W + 1) / 2);
    // Node 0 carries the constant carry-in; node k>0 is operand bit k-1.
    logic [W-1:0] gx, tx;
    logic [W-1:0] hl [LV+1];
    logic [W-1:0] cx;

    assign gx = {opa[W-2:0] & opb[W-2:0], 1'b1};
    assign tx = {opa[W-2:0] | opb[W-2:0], 1'b1};

    assign hl[0][0] = gx[0];
    assign hl[0][W-1:1] = gx[W-1:1] | gx[W-2:0];

    for (genvar l = 0; l < LV; l++) begin : g_lvl
      localparam int D = 2 << l;
      for (genvar k = 0; k < W; k++) begin : g_node
        if (k >= D) begin : g_comb
          assign hl[l+1][k] = hl[l][k] | ((&tx[k-1:k-D]) & hl[l][k-D]);
        end else begin : g_pass
          assign hl[l+1][k] = hl[l][k];
        end
      end
    end

    assign cx = tx & hl[LV];
    assign result = opa ^ opb ^ cx;
  end

endmodule

// File: rtl/rb_to_binary_chk.sv
module rb_to_binary_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] pos_row,
  input logic [W-1:0] neg_row,
  input logic [W-1:0] result
);

  always_comb begin
    a_r1_difference: assert (result == W'(pos_row - neg_row))
      else $error("R1 difference mismatch");
    a_r1_round_trip: assert (W'(result + neg_row) == pos_row)
      else $error("R1 round trip mismatch");
    if (neg_row == '0)
      a_r3_zero_subtrahend: assert (result == pos_row)
        else $error("R3 zero subtrahend");
    if (pos_row == neg_row)
      a_r4_equal_rows: assert (result == '0)
        else $error("R4 equal rows");
    if (pos_row == '0)
      a_r6_negation: assert (W'(result + neg_row) == '0)
        else $error("R6 negation");
  end

endmodule

bind rb_to_binary rb_to_binary_chk #(.W(W)) u_chk (
  .pos_row(pos_row),
  .neg_row(neg_row),
  .result (result)
);

// File: tb/tb_rb_to_binary.sv
module tb_rb_to_binary;
  localparam int W = 32;

  typedef struct {
    logic [W-1:0] pa;
    logic [W-1:0] na;
    logic [W-1:0] exp;
    string        tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] pos_row = '0, neg_row = '0;
  logic [W-1:0] res_pf, res_rc;
  int checks = 0, failures = 0;
  bit done = 1'b0;
  item_t sb[$];

  always #2 clk = ~clk;

  rb_to_binary #(.W(W), .USE_RIPPLE(1'b0)) dut (
    .pos_row(pos_row), .neg_row(neg_row), .result(res_pf));
  rb_to_binary #(.W(W), .USE_RIPPLE(1'b1)) dut_rc (
    .pos_row(pos_row), .neg_row(neg_row), .result(res_rc));

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] p, input logic [W-1:0] n, input string tag);
    item_t it;
    @(negedge clk);
    pos_row = p;
    neg_row = n;
    it.pa = p; it.na = n; it.exp = W'(p - n); it.tag = tag;
    sb.push_back(it);
    @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check({it.tag, " prefix"}, res_pf, it.exp);
      check({it.tag, " ripple"}, res_rc, it.exp);
      check("R5 variants agree", res_rc, res_pf);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 reset state prefix", res_pf, '0);
    check("R2 reset state ripple", res_rc, '0);
    rst = 1'b0;

    drive('0, '0, "R2 zeros");
    drive('1, '0, "R7 ones minus zero");
    @(negedge clk); check("R7 all ones", res_pf, '1);
    drive('0, '1, "R7 zero minus ones");
    @(negedge clk); check("R6 negate ones gives 1", res_pf, 32'h1);
    drive(32'hAAAAAAAA, 32'h55555555, "R8 alt A-5");
    @(negedge clk); check("R8 alt A-5 value", res_pf, 32'h55555555);
    drive(32'h55555555, 32'hAAAAAAAA, "R8 alt 5-A");
    @(negedge clk); check("R8 alt 5-A value", res_rc, 32'hAAAAAAAB);
    drive(32'h12345678, 32'h12345678, "R4 equal rows");
    drive('1, '1, "R4 equal ones");
    drive(32'hDEADBEEF, '0, "R3 zero subtrahend");
    @(negedge clk); check("R3 passthrough", res_pf, 32'hDEADBEEF);
    drive('0, 32'h80000000, "R6 sign bit negation");
    @(negedge clk); check("R6 sign bit value", res_pf, 32'h80000000);
    drive('0, 32'h00000001, "R6 negate one");
    drive(32'h80000000, 32'h00000001, "R1 wrap at sign");
    for (int i = 0; i < 400; i++) begin
      drive($urandom, $urandom, "R1 random");
    end
    for (int i = 0; i < 50; i++) begin
      logic [W-1:0] v;
      v = $urandom;
      drive(v, v, "R4 random equal");
    end
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule